// File: doc/BRIEF.md
# Serial Code Lock Link

This block joins two ends of a combination lock through one serial wire. On the key end, a code word set on parallel switch inputs is captured into a four-mode shift register when the `send_i` strobe is seen. It goes out on the wire as one start bit of 1 followed by the code bits, most significant first, one per clock. On the lock end, a second register of the same kind waits for the start bit and then collects exactly `W` bits by shifting. It then holds the word while a bitwise equality comparator checks it against the lock's stored code.

When every bit agrees, the lock end raises a registered unlock pulse for one clock. A mismatch leaves the unlock output low. In either case the receiver goes back to waiting for a start bit. Both ends run from one clock. The wire is modelled as a clocked digital line and is brought out on `line_o` for observation.

Both shift registers take a two-bit mode `{s1,s0}`: 2'b00 holds, 2'b10 moves each bit one place up with bit 0 taking the up-serial input, 2'b01 moves each bit one place down with the top bit taking the down-serial input, and 2'b11 loads the parallel input. The active-low reset clears a register in any mode.

Top module: `code_link`

## Requirements
- R1: After reset, `busy_o`, `line_o` and `unlock_o` are all 0.
- R2: When `send_i` is 1 at a rising edge while `busy_o` is 0, `busy_o` is 1 for exactly W+1 cycles, starting in the cycle after that edge.
- R3: In the first busy cycle `line_o` is 1 (the start bit). In busy cycle k+1 (k = 0..W-1) it carries `key_code_i[W-1-k]`, as sampled at the accepting edge. `line_o` is 0 whenever `busy_o` is 0.
- R4: A `send_i` strobe seen while `busy_o` is 1 has no effect: the bit sequence and the busy length of the running transfer are unchanged.
- R5: Changes to `key_code_i` after the accepting edge do not alter the bits sent in that transfer.
- R6: When the received word equals `lock_code_i`, `unlock_o` is 1 for exactly one cycle. That cycle begins at the (W+2)th rising edge after the accepting edge.
- R7: If any received bit differs from `lock_code_i`, including a single-bit difference, `unlock_o` stays 0.
- R8: With `send_i` held at 1, a new transfer starts every W+2 cycles. Its start bit is on the line in the same cycle as the previous transfer's unlock pulse, and the receiver still accepts it.
- R9: Each shift register holds its contents in mode 2'b00 and captures its parallel input in mode 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_i | input | 1 | Transfer request, sampled at the rising edge |
| key_code_i | input | W | Switch code on the key end |
| lock_code_i | input | W | Stored code on the lock end |
| busy_o | output | 1 | Key end transfer in progress |
| line_o | output | 1 | Serial wire between the ends |
| unlock_o | output | 1 | One-cycle unlock pulse |

## Verification
Two functions can fall in the same cycle: the lock end finishing its comparison and pulsing unlock, and the key end putting the start bit of a new transfer on the wire. The bench provokes this by holding `send_i` high across two transfers with matching codes. It checks that the start bit appears during the first unlock pulse and that the second unlock pulse follows exactly W+2 cycles later. The table of matching and single-bit-error codes, and a strobe plus switch change in the middle of a transfer, cover the remaining timing.

// File: rtl/code_link_pkg.sv
package code_link_pkg;
  // {s1,s0}
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_LOAD = 2'b11
  } shmode_e;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA} tx_state_e;
  typedef enum logic [1:0] {RX_WAIT, RX_SHIFT, RX_CMP} rx_state_e;
endpackage

// File: rtl/univ_shreg.sv
module univ_shreg
  import code_link_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  shmode_e      mode_i,
  input  logic [W-1:0] par_i,
  input  logic         up_in_i,
  input  logic         dn_in_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else begin
      case (mode_i)
        MODE_UP:   q <= {q[W-2:0], up_in_i};
        MODE_DOWN: q <= {dn_in_i, q[W-1:1]};
        MODE_LOAD: q <= par_i;
        default:   q <= q;
      endcase
    end
  end

  assign q_o = q;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_HOLD |=> $stable(q_o));
  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_LOAD |=> q_o == $past(par_i));
endmodule

// File: rtl/eq_cmp.sv
module eq_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] same;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic diff;
    assign diff    = a_i[i] ^ b_i[i];
    assign same[i] = ~diff;
  end

  assign eq_o = &same;
endmodule

// File: rtl/key_tx.sv
module key_tx
  import code_link_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         send_i,
  input  logic [W-1:0] code_i,
  output logic         serial_o,
  output logic         busy_o
);
  localparam int CW = $clog2(W + 1);

  tx_state_e    st;
  logic [CW-1:0] cnt;
  shmode_e      mode;
  logic [W-1:0] rev_code;
  logic [W-1:0] q;

  // reversed load puts the MSB at bit 0, which leaves first when shifting down
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_code[i] = code_i[W-1-i];
  end

  always_comb begin
    mode = MODE_HOLD;
    if (st == TX_IDLE && send_i) mode = MODE_LOAD;
    else if (st == TX_DATA)      mode = MODE_DOWN;
  end

  univ_shreg #(.W(W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .par_i  (rev_code),
    .up_in_i(1'b0),
    .dn_in_i(1'b0),
    .q_o    (q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= TX_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        TX_IDLE:  if (send_i) st <= TX_START;
        TX_START: begin
          st  <= TX_DATA;
          cnt <= '0;
        end
        TX_DATA: begin
          if (cnt == CW'(W - 1)) st <= TX_IDLE;
          cnt <= cnt + 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign serial_o = (st == TX_START) | ((st == TX_DATA) & q[0]);
  assign busy_o   = (st != TX_IDLE);

  a_r2_busy_from_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(send_i));
  a_r5_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == TX_START) |-> q == $past(rev_code));
  a_r3_idle_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !serial_o);
endmodule

// File: rtl/lock_rx.sv
module lock_rx
  import code_link_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         serial_i,
  input  logic [W-1:0] code_i,
  output logic         unlock_o
);
  localparam int CW = $clog2(W + 1);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  shmode_e       mode;
  logic [W-1:0]  word;
  logic          match;
  logic          unlock_q;

  assign mode = (st == RX_SHIFT) ? MODE_UP : MODE_HOLD;

  univ_shreg #(.W(W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .par_i  ('0),
    .up_in_i(serial_i),
    .dn_in_i(1'b0),
    .q_o    (word)
  );

  eq_cmp #(.W(W)) u_cmp (
    .a_i (word),
    .b_i (code_i),
    .eq_o(match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= RX_WAIT;
      cnt      <= '0;
      unlock_q <= 1'b0;
    end else begin
      unlock_q <= (st == RX_CMP) & match;
      case (st)
        RX_WAIT: if (serial_i) begin
          st  <= RX_SHIFT;
          cnt <= '0;
        end
        RX_SHIFT: begin
          if (cnt == CW'(W - 1)) st <= RX_CMP;
          cnt <= cnt + 1'b1;
        end
        RX_CMP:  st <= RX_WAIT;
        default: st <= RX_WAIT;
      endcase
    end
  end

  assign unlock_o = unlock_q;

  a_r7_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> $past(word == code_i));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> !unlock_o);
endmodule

// File: rtl/code_link.sv
module code_link #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         send_i,
  input  logic [W-1:0] key_code_i,
  input  logic [W-1:0] lock_code_i,
  output logic         busy_o,
  output logic         line_o,
  output logic         unlock_o
);
  logic line;

  key_tx #(.W(W)) u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .send_i  (send_i),
    .code_i  (key_code_i),
    .serial_o(line),
    .busy_o  (busy_o)
  );

  lock_rx #(.W(W)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .serial_i(line),
    .code_i  (lock_code_i),
    .unlock_o(unlock_o)
  );

  assign line_o = line;
endmodule

// File: tb/tb_code_link.sv
`timescale 1ns/1ps
module tb_code_link;
  localparam int W = 4;
  localparam int NV = 6;
  // {key, lock, expect_unlock}
  localparam logic [2*W:0] VEC [NV] = '{
    {4'b1011, 4'b1011, 1'b1},
    {4'b0000, 4'b0000, 1'b1},
    {4'b1111, 4'b1111, 1'b1},
    {4'b1011, 4'b1010, 1'b0},
    {4'b0110, 4'b1110, 1'b0},
    {4'b1001, 4'b1000, 1'b0}
  };

  logic clk = 0, rst_n = 0, send = 0;
  logic [W-1:0] key = '0, lock = '0;
  logic busy, line, unlock;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  code_link #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .send_i(send),
    .key_code_i(key), .lock_code_i(lock),
    .busy_o(busy), .line_o(line), .unlock_o(unlock)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // call right after the negedge that follows the accepting edge
  task automatic follow(input logic [W-1:0] k, input logic exp_unlock, input bit disturb);
    chk("R2 busy start", busy, 1'b1);
    chk("R3 start bit", line, 1'b1);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (disturb && i == 1) begin
        send = 1;
        key  = ~k;
      end else send = 0;
      chk("R3 data bit", line, k[W-1-i]);
      chk("R2 busy held", busy, 1'b1);
      if (disturb) chk("R4 R5 unchanged", line, k[W-1-i]);
    end
    @(negedge clk);
    send = 0;
    chk("R2 busy end", busy, 1'b0);
    chk("R3 idle line", line, 1'b0);
    chk("R6 no early unlock", unlock, 1'b0);
    @(negedge clk);
    if (exp_unlock) chk("R6 unlock", unlock, 1'b1);
    else chk("R7 mismatch", unlock, 1'b0);
    chk("R4 no restart", busy, 1'b0);
    @(negedge clk);
    chk("R6 one cycle", unlock, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 1'b0);
    chk("R1 line", line, 1'b0);
    chk("R1 unlock", unlock, 1'b0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[v]) begin
      key  = VEC[v][2*W:W+1];
      lock = VEC[v][W:1];
      send = 1;
      @(negedge clk);
      send = 0;
      follow(key, VEC[v][0], 1'b0);
      @(negedge clk);
    end

    // R4/R5: strobe and switch change during a transfer
    key = 4'b1100; lock = 4'b1100; send = 1;
    @(negedge clk);
    send = 0;
    follow(4'b1100, 1'b1, 1'b1);
    @(negedge clk);

    // R8: send held high, start bit coincides with unlock pulse
    key = 4'b1011; lock = 4'b1011; send = 1;
    @(negedge clk);
    for (int i = 0; i < W + 1; i++) @(negedge clk);
    chk("R8 gap", busy, 1'b0);
    @(negedge clk);
    chk("R8 unlock", unlock, 1'b1);
    chk("R8 start bit overlap", line, 1'b1);
    chk("R8 busy again", busy, 1'b1);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      chk("R8 data", line, key[W-1-i]);
    end
    send = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 second unlock", unlock, 1'b1);
    @(negedge clk);
    chk("R8 pulse ends", unlock, 1'b0);

    // R7: corrupted start-aligned words never unlock
    key = 4'b0111; lock = 4'b0011; send = 1;
    @(negedge clk);
    send = 0;
    for (int i = 0; i < W + 4; i++) begin
      @(negedge clk);
      chk("R7 held low", unlock, 1'b0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule